// File: doc/BRIEF.md
# Request/Grant Bus Handoff Controller

This block is the processor-side arbiter for a small number of single-wire request/grant channels (two by default). Over each channel another local bus master can borrow the processor's bus. The exchange on a line is three active-low pulses, each one clock wide. First the master requests. Then the processor answers with a grant and floats its bus. Later the master pulses once more to hand the bus back. Each bidirectional line appears here as a sampled input plus a drive-low enable, which the pad logic outside the block turns into an open-drain driver.

The controller follows the bus sequencer's phase code, along with the lock, first interrupt-acknowledge and low-byte-of-word indications. From these it decides when a grant may be driven. While a master holds the bus, it asserts a float indication and tells the sequencer to hold off new cycles. It returns the bus one clock after the release pulse, then enforces an idle clock before the next exchange can start. The lowest-numbered channel has priority. A request that arrives while another channel holds the bus stays pending until its turn comes.

Top module: `bus_handoff_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `rqgt_drive_low`, `bus_float` and `hold_cycles` are all 0, and no request is pending.
- R2: At most one bit of `rqgt_drive_low` is 1 in any cycle. A grant bit is 1 for a single cycle, and only when `bus_phase` is idle (code 0) or T4 (code 4). The phase codes are idle=0, T1=1, T2=2, T3=3, T4=4, wait=5.
- R3: During a bus cycle, a pending request is granted in that cycle's T4 only if three things hold: the request line was first sampled low during idle, T1, T2 or T4 (not T3 or wait); `word_low` is 0; and `inta_first` is 0. A request first seen in T3 or wait is served at a later T4.
- R4: No grant is driven while `lock_active` is 1, on an idle bus or at T4. The pending request is granted in the first eligible cycle after the lock drops.
- R5: On an idle bus, with lock inactive, a request pulse sampled in cycle k produces the grant pulse in cycle k+1.
- R6: `bus_float` rises in the cycle after the grant pulse. It stays 1 through the cycle in which the owning master's release pulse is low, and falls in the next cycle. No grant is driven while it is 1.
- R7: `hold_cycles` is 1 during the grant cycle and in every cycle in which `bus_float` is 1.
- R8: When two channels are pending in the same eligible cycle, the lower-numbered channel is granted.
- R9: In the cycle in which `bus_float` falls, no grant is driven, even if a request is pending.
- R10: A request on one channel while another channel holds the bus is remembered. It is granted two cycles after the release pulse, once the idle cycle has passed.
- R11: Each request pulse produces exactly one grant pulse on its own channel. The line being low during the processor's own grant, or during the owner's release pulse, does not count as a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_phase | input | 3 | Sequencer phase: 0 idle, 1 T1, 2 T2, 3 T3, 4 T4, 5 wait |
| word_low | input | 1 | Current cycle is the low byte of a word transfer |
| inta_first | input | 1 | Current cycle is the first interrupt-acknowledge cycle |
| lock_active | input | 1 | A locked instruction is executing |
| rqgt_in | input | NCH | Sampled level of each request/grant line (low = pulse) |
| rqgt_drive_low | output | NCH | Pull the line low this cycle (grant pulse) |
| bus_float | output | 1 | Bus is handed to another master |
| hold_cycles | output | 1 | Sequencer must not start a new bus cycle |

## Verification
The assertions assume that the external masters keep to the protocol. Each pulse lasts exactly one clock. A master does not request again while its earlier request is outstanding. It sends a release only while it owns the bus, and it leaves the line high during the processor's grant cycle. The bench's master model enforces these rules on each channel, whether it is running directed sequences or random traffic. The random traffic varies phase codes and the lock, word and acknowledge flags freely, because the controller must stay safe under any phase sequence.

// File: rtl/rgc_pkg.sv
package rgc_pkg;
  typedef enum logic [2:0] {
    BS_IDLE = 3'd0,
    BS_T1   = 3'd1,
    BS_T2   = 3'd2,
    BS_T3   = 3'd3,
    BS_T4   = 3'd4,
    BS_TW   = 3'd5
  } bus_phase_t;

  typedef enum logic [1:0] {
    XS_OWN   = 2'd0,
    XS_FLOAT = 2'd1,
    XS_GAP   = 2'd2
  } xfer_state_t;
endpackage

// File: rtl/rgc_line_mon.sv
module rgc_line_mon
  import rgc_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  bus_phase_t     phase,
  input  logic [NCH-1:0] line_low,
  input  logic [NCH-1:0] capture_en,
  input  logic [NCH-1:0] grant_onehot,
  output logic [NCH-1:0] pending,
  output logic [NCH-1:0] late
);
  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        pending[gi] <= 1'b0;
        late[gi]    <= 1'b0;
      end else if (grant_onehot[gi]) begin
        pending[gi] <= 1'b0;
        late[gi]    <= 1'b0;
      end else if (capture_en[gi] && line_low[gi] && !pending[gi]) begin
        pending[gi] <= 1'b1;
        late[gi]    <= (phase == BS_T3) || (phase == BS_TW);
      end else if (phase == BS_T4) begin
        late[gi]    <= 1'b0;
      end
    end

    AST_LATE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
      (late[gi] && phase == BS_T4) |-> !grant_onehot[gi]); // R3
  end
endmodule

// File: rtl/rgc_arbiter.sv
module rgc_arbiter
  import rgc_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int IDX_W = 1
) (
  input  bus_phase_t       phase,
  input  logic [NCH-1:0]   pending,
  input  logic [NCH-1:0]   late,
  input  logic             word_low,
  input  logic             inta_first,
  input  logic             lock_active,
  input  logic             arb_en,
  output logic [NCH-1:0]   grant_onehot,
  output logic [IDX_W-1:0] grant_idx
);
  logic cycle_ok;
  logic go;

  always_comb begin
    grant_idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pending[i]) grant_idx = IDX_W'(i);
    end
  end

  always_comb begin
    cycle_ok = 1'b0;
    if (!lock_active) begin
      if (phase == BS_IDLE) cycle_ok = 1'b1;
      else if (phase == BS_T4) cycle_ok = !word_low && !inta_first && !late[grant_idx];
    end
    go           = arb_en && (|pending) && cycle_ok;
    grant_onehot = go ? (NCH'(1) << grant_idx) : '0;
  end
endmodule

// File: rtl/rgc_xfer_fsm.sv
module rgc_xfer_fsm
  import rgc_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int IDX_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   line_low,
  input  logic [NCH-1:0]   grant_onehot,
  input  logic [IDX_W-1:0] grant_idx,
  output logic             arb_en,
  output logic             bus_float,
  output logic [NCH-1:0]   capture_en
);
  xfer_state_t      state;
  logic [IDX_W-1:0] owner;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= XS_OWN;
      owner <= '0;
    end else begin
      case (state)
        XS_OWN: if (|grant_onehot) begin
          state <= XS_FLOAT;
          owner <= grant_idx;
        end
        XS_FLOAT: if (line_low[owner]) state <= XS_GAP;
        XS_GAP: state <= XS_OWN;
        default: state <= XS_OWN;
      endcase
    end
  end

  assign arb_en    = (state == XS_OWN);
  assign bus_float = (state == XS_FLOAT);

  for (genvar gi = 0; gi < NCH; gi++) begin : g_cap
    assign capture_en[gi] = !((state == XS_FLOAT) && (owner == IDX_W'(gi)));
  end

  AST_RELEASE_RETURNS: assert property (@(posedge clk) disable iff (rst)
    (bus_float && line_low[owner]) |=> !bus_float); // R6
endmodule

// File: rtl/bus_handoff_ctrl.sv
module bus_handoff_ctrl
  import rgc_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2:0]     bus_phase,
  input  logic           word_low,
  input  logic           inta_first,
  input  logic           lock_active,
  input  logic [NCH-1:0] rqgt_in,
  output logic [NCH-1:0] rqgt_drive_low,
  output logic           bus_float,
  output logic           hold_cycles
);
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

  bus_phase_t       phase;
  logic [NCH-1:0]   line_low;
  logic [NCH-1:0]   capture_en;
  logic [NCH-1:0]   pending;
  logic [NCH-1:0]   late;
  logic [NCH-1:0]   grant_onehot;
  logic [IDX_W-1:0] grant_idx;
  logic             arb_en;

  assign phase    = bus_phase_t'(bus_phase);
  assign line_low = ~rqgt_in;

  rgc_line_mon #(.NCH(NCH)) u_mon (
    .clk(clk), .rst(rst), .phase(phase), .line_low(line_low),
    .capture_en(capture_en), .grant_onehot(grant_onehot),
    .pending(pending), .late(late)
  );

  rgc_arbiter #(.NCH(NCH), .IDX_W(IDX_W)) u_arb (
    .phase(phase), .pending(pending), .late(late), .word_low(word_low),
    .inta_first(inta_first), .lock_active(lock_active), .arb_en(arb_en),
    .grant_onehot(grant_onehot), .grant_idx(grant_idx)
  );

  rgc_xfer_fsm #(.NCH(NCH), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst(rst), .line_low(line_low), .grant_onehot(grant_onehot),
    .grant_idx(grant_idx), .arb_en(arb_en), .bus_float(bus_float),
    .capture_en(capture_en)
  );

  assign rqgt_drive_low = grant_onehot;
  assign hold_cycles    = (|grant_onehot) || bus_float;

  AST_DRIVE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rqgt_drive_low)); // R2
  AST_DRIVE_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (|rqgt_drive_low) |-> ((phase == BS_IDLE || phase == BS_T4) && !lock_active)); // R4
  AST_FLOAT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (|rqgt_drive_low) |=> bus_float); // R6
  AST_NO_DRIVE_FLOAT: assert property (@(posedge clk) disable iff (rst)
    bus_float |-> (rqgt_drive_low == '0)); // R6
  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_float) |-> (rqgt_drive_low == '0)); // R9
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (|rqgt_drive_low) |=> (rqgt_drive_low == '0)); // R2
endmodule

// File: tb/bus_handoff_ctrl_test.sv
module bus_handoff_ctrl_test;
  localparam logic [2:0] PI = 3'd0, P1 = 3'd1, P2 = 3'd2, P3 = 3'd3, P4 = 3'd4, PW = 3'd5;

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] bus_phase;
  logic       word_low, inta_first, lock_active;
  logic [1:0] rqgt_in;
  logic [1:0] rqgt_drive_low;
  logic       bus_float, hold_cycles;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [1:0] o_drv;
  logic       o_flt, o_hold;

  bus_handoff_ctrl #(.NCH(2)) uut (
    .clk(clk), .rst(rst), .bus_phase(bus_phase), .word_low(word_low),
    .inta_first(inta_first), .lock_active(lock_active), .rqgt_in(rqgt_in),
    .rqgt_drive_low(rqgt_drive_low), .bus_float(bus_float), .hold_cycles(hold_cycles)
  );

  always #4 clk = ~clk;

  task automatic chk(input string r, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", r, act, exp);
    end
  endtask

  // One clock: inputs set after the falling edge, outputs captured before the rising edge.
  task automatic step(input logic [2:0] ph, input logic [1:0] lo,
                      input logic wl = 1'b0, input logic ia = 1'b0, input logic lk = 1'b0);
    bus_phase = ph; rqgt_in = ~lo; word_low = wl; inta_first = ia; lock_active = lk;
    #2;
    o_drv = rqgt_drive_low; o_flt = bus_float; o_hold = hold_cycles;
    @(negedge clk);
  endtask

  task automatic release_ch(input int ch);
    step(PI, 2'(1 << ch)); chk("R6 float held in release cycle", o_flt, 1);
    step(PI, 2'b00);       chk("R6 float drops after release", o_flt, 0);
    step(PI, 2'b00);
  endtask

  // Master model for random traffic
  int m_st[2];
  int m_cnt[2];
  int nreq = 0, ngr = 0;
  bit drain = 1'b0;
  logic [1:0] p_drv;
  logic       p_flt;

  initial begin
    #(8 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; bus_phase = PI; rqgt_in = 2'b11; word_low = 0; inta_first = 0; lock_active = 0;
    @(negedge clk);
    step(PI, 2'b00);
    chk("R1 drive in reset", o_drv, 0); chk("R1 float in reset", o_flt, 0); chk("R1 hold in reset", o_hold, 0);
    rst = 1'b0;
    step(PI, 2'b00);
    chk("R1 drive after reset", o_drv, 0); chk("R1 float after reset", o_flt, 0);
    step(PI, 2'b00);
    chk("R1 no pending after reset", o_drv, 0);

    // R5 idle grant timing, R6/R7
    step(PI, 2'b01); chk("R5 no grant in request cycle", o_drv, 0);
    step(PI, 2'b00); chk("R5 grant next cycle", o_drv, 1); chk("R7 hold in grant cycle", o_hold, 1);
    chk("R6 no float in grant cycle", o_flt, 0);
    step(PI, 2'b00); chk("R6 float after grant", o_flt, 1); chk("R7 hold during float", o_hold, 1);
    chk("R2 single-cycle grant", o_drv, 0);
    step(PI, 2'b00); chk("R6 float held", o_flt, 1);
    release_ch(0);
    step(PI, 2'b00); chk("R11 release not a request", o_drv, 0);

    // R3 request at T2 -> grant at T4
    step(P1, 2'b00); step(P2, 2'b01); step(P3, 2'b00); chk("R3 no grant in T3", o_drv, 0);
    step(P4, 2'b00); chk("R3 grant at T4", o_drv, 1);
    step(PI, 2'b00); chk("R6 float after T4 grant", o_flt, 1);
    release_ch(0);

    // R3 request at T3 is late
    step(P1, 2'b00); step(P2, 2'b00); step(P3, 2'b01);
    step(P4, 2'b00); chk("R3 late request not granted at this T4", o_drv, 0);
    step(P1, 2'b00); step(P2, 2'b00); step(P3, 2'b00); chk("R3 no grant in T3", o_drv, 0);
    step(P4, 2'b00); chk("R3 late request granted next T4", o_drv, 1);
    step(PI, 2'b00); release_ch(0);

    // R3 word low byte blocks
    step(P1, 2'b10); step(P2, 2'b00); step(P3, 2'b00);
    step(P4, 2'b00, 1'b1); chk("R3 low byte blocks", o_drv, 0);
    step(P1, 2'b00); step(P2, 2'b00); step(P3, 2'b00);
    step(P4, 2'b00); chk("R3 grant after word completes", o_drv, 2);
    step(PI, 2'b00); release_ch(1);

    // R3 first interrupt acknowledge blocks
    step(P1, 2'b01); step(P2, 2'b00); step(P3, 2'b00);
    step(P4, 2'b00, 1'b0, 1'b1); chk("R3 first acknowledge blocks", o_drv, 0);
    step(P1, 2'b00); step(P2, 2'b00); step(P3, 2'b00);
    step(P4, 2'b00); chk("R3 grant after acknowledge", o_drv, 1);
    step(PI, 2'b00); release_ch(0);

    // R4 lock
    step(PI, 2'b01, 0, 0, 1);
    step(PI, 2'b00, 0, 0, 1); chk("R4 locked idle no grant", o_drv, 0);
    step(P4, 2'b00, 0, 0, 1); chk("R4 locked T4 no grant", o_drv, 0);
    step(PI, 2'b00, 0, 0, 0); chk("R4 grant after unlock", o_drv, 1);
    step(PI, 2'b00); release_ch(0);

    // R8 priority, R9 gap, R10 deferred
    step(PI, 2'b11); chk("R8 request cycle", o_drv, 0);
    step(PI, 2'b00); chk("R8 channel 0 wins", o_drv, 1);
    step(PI, 2'b00); chk("R6 float", o_flt, 1);
    step(PI, 2'b01); chk("R6 float in release", o_flt, 1);
    step(PI, 2'b00); chk("R9 float fell", o_flt, 0); chk("R9 no grant in gap", o_drv, 0);
    step(PI, 2'b00); chk("R10 deferred channel 1 granted", o_drv, 2);
    step(PI, 2'b00); release_ch(1);

    // R10 request during another channel's ownership
    step(PI, 2'b01);
    step(PI, 2'b00); chk("R10 ch0 grant", o_drv, 1);
    step(PI, 2'b10); chk("R10 float kept", o_flt, 1); chk("R6 no grant in float", o_drv, 0);
    step(PI, 2'b00);
    step(PI, 2'b01);
    step(PI, 2'b00); chk("R9 no grant in gap", o_drv, 0);
    step(PI, 2'b00); chk("R10 ch1 served after ch0", o_drv, 2);
    step(PI, 2'b00); release_ch(1);
    step(PI, 2'b00);

    // Random traffic with protocol-following masters
    p_drv = 2'b00; p_flt = 1'b0;
    for (int c = 0; c < 3200; c++) begin
      logic [1:0] lo;
      logic [2:0] ph;
      lo = 2'b00;
      if (c == 3000) drain = 1'b1;
      for (int ch = 0; ch < 2; ch++) begin
        case (m_st[ch])
          0: if (!drain && ($urandom % 6) == 0) begin lo[ch] = 1'b1; m_st[ch] = 1; nreq++; end
          2: if (m_cnt[ch] == 0) begin lo[ch] = 1'b1; m_st[ch] = 3; m_cnt[ch] = 2; end
             else m_cnt[ch]--;
          3: if (m_cnt[ch] == 0) m_st[ch] = 0; else m_cnt[ch]--;
          default: ;
        endcase
      end
      ph = drain ? PI : 3'($urandom % 6);
      if (drain) step(ph, lo);
      else step(ph, lo, 1'(($urandom % 4) == 0), 1'(($urandom % 4) == 0), 1'(($urandom % 6) == 0));
      for (int ch = 0; ch < 2; ch++) begin
        if (o_drv[ch]) begin
          ngr++;
          chk("R11 grant only to requester", m_st[ch], 1);
          m_st[ch] = 2; m_cnt[ch] = int'($urandom % 4);
        end
      end
      chk("R2 one grant at a time", int'($countones(o_drv) <= 1), 1);
      if (o_drv != 2'b00)
        chk("R4 grant only idle/T4 unlocked",
            int'((bus_phase == PI || bus_phase == P4) && !lock_active), 1);
      if (p_drv != 2'b00) chk("R6 float after grant", o_flt, 1);
      if (o_flt) begin chk("R6 no grant while floated", o_drv, 0); chk("R7 hold while floated", o_hold, 1); end
      if (p_flt && !o_flt) chk("R9 no grant in gap", o_drv, 0);
      p_drv = o_drv; p_flt = o_flt;
    end
    chk("R11 grants equal requests", ngr, nreq);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule